// File: doc/BRIEF.md
# Lane-to-Lane Transfer Fabric

This block is the communication fabric that links a row of processing lanes in a data-parallel array. Each lane presents one 16-bit word on its slice of a wide input bus. A single command, given with its mode, source lane, destination lane and memory address, starts one transfer over the whole row.

Four transfer kinds are supported. Two are row shifts, one to the right and one to the left, and each lane receives its neighbour's word. The third is a one-to-all copy of a chosen lane's word. The fourth is a point-to-point store, in which one lane's word is written into a chosen address of another lane's local memory through a shared write port. Shifts and copies deliver their result one cycle after the command is accepted. A point-to-point store takes two cycles and holds the fabric busy until it is done.

The fabric captures the lane words at the edge that accepts a command. The lanes may therefore keep computing and changing their words while a transfer is in flight. A one-cycle completion pulse marks the cycle in which the result appears.

Top module: `lane_xfer_fabric`

## Requirements
- R1: After reset, busy_o, done_o, every rx_valid_o bit and every wr_en_o bit are 0, and rx_data_o is all zeros.
- R2: Mode 0 (shift right), once accepted, sets rx_data_o of lane i to the word of lane i-1 in the next cycle. Lane 0 receives zero, and all rx_valid_o bits are 1 for that cycle.
- R3: Mode 1 (shift left), once accepted, sets rx_data_o of lane i to the word of lane i+1 in the next cycle. The last lane receives zero, and all rx_valid_o bits are 1 for that cycle.
- R4: Mode 2 (copy) delivers the word of lane cmd_src_i to every other lane in the next cycle, with their rx_valid_o bits at 1. The source lane's rx_valid_o stays 0 and its rx_data_o takes its own unchanged word.
- R5: Mode 3 (point-to-point store) asserts exactly one wr_en_o bit, the one at index cmd_dst_i, two cycles after acceptance. In that cycle wr_addr_o equals cmd_addr_i and wr_data_o equals the source lane's word as sampled at the accepting edge.
- R6: busy_o is 1 for exactly the one cycle between the acceptance of a store and its write. A command presented while busy_o is 1 is ignored: it produces no rx_valid_o, no change of rx_data_o and no write.
- R7: done_o is 1 in exactly the cycles in which a transfer delivers its result (any rx_valid_o or wr_en_o bit set), and it is 0 otherwise.
- R8: At most one wr_en_o bit is 1 in any cycle.
- R9: A store never asserts rx_valid_o, and rx_data_o keeps its previous contents across a store. A shift or a copy never asserts wr_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_mode_i | input | 2 | 0 shift right, 1 shift left, 2 copy, 3 store |
| cmd_src_i | input | IW | Source lane index |
| cmd_dst_i | input | IW | Destination lane index for a store |
| cmd_addr_i | input | AW | Memory address for a store |
| lane_data_i | input | N*W | Word of each lane, lane i at bits i*W +: W |
| rx_data_o | output | N*W | Word delivered to each lane |
| rx_valid_o | output | N | Per-lane delivery strobe |
| wr_en_o | output | N | One-hot write enable into lane memories |
| wr_addr_o | output | AW | Store address |
| wr_data_o | output | W | Store data |
| busy_o | output | 1 | Store in flight, commands ignored |
| done_o | output | 1 | Transfer completes this cycle |

## Verification
Random lane words are pushed through both shift directions. This separates the right and left neighbour wiring and shows that zero is fed at the correct end of the row. Copies are issued from the first lane, the last lane and a middle lane, which shows that the source lane is excluded and that the selector decodes every index. Stores go to both end lanes. Commands are issued during the busy cycle together with lane words that change after acceptance, which separates capture-at-acceptance from late sampling and shows whether rejection works. A long stretch of random back-to-back commands checks that completion never overlaps with a pending store.

// File: rtl/lxf_pkg.sv
package lxf_pkg;
  typedef enum logic [1:0] {
    XF_SHR   = 2'd0,
    XF_SHL   = 2'd1,
    XF_BCAST = 2'd2,
    XF_STORE = 2'd3
  } xfer_mode_e;
endpackage

// File: rtl/lxf_router.sv
module lxf_router
  import lxf_pkg::*;
#(
  parameter int N  = 64,
  parameter int W  = 16,
  parameter int IW = $clog2(N)
) (
  input  xfer_mode_e       mode_i,
  input  logic [IW-1:0]    src_i,
  input  logic [N*W-1:0]   lane_data_i,
  output logic [N*W-1:0]   nxt_data_o,
  output logic [N-1:0]     nxt_valid_o
);
  logic [W-1:0] lane_arr [N];
  logic [W-1:0] bc_word;

  for (genvar i = 0; i < N; i++) begin : g_unpack
    assign lane_arr[i] = lane_data_i[i*W +: W];
  end

  assign bc_word = lane_arr[src_i];

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [W-1:0] from_lo, from_hi;
    if (i == 0) begin : g_lo_edge
      assign from_lo = '0;
    end else begin : g_lo
      assign from_lo = lane_arr[i-1];
    end
    if (i == N-1) begin : g_hi_edge
      assign from_hi = '0;
    end else begin : g_hi
      assign from_hi = lane_arr[i+1];
    end

    always_comb begin
      nxt_data_o[i*W +: W] = lane_arr[i];
      nxt_valid_o[i]       = 1'b0;
      unique case (mode_i)
        XF_SHR: begin
          nxt_data_o[i*W +: W] = from_lo;
          nxt_valid_o[i]       = 1'b1;
        end
        XF_SHL: begin
          nxt_data_o[i*W +: W] = from_hi;
          nxt_valid_o[i]       = 1'b1;
        end
        XF_BCAST: begin
          // source keeps its own word and raises no strobe
          nxt_data_o[i*W +: W] = bc_word;
          nxt_valid_o[i]       = (src_i != IW'(i));
        end
        default: begin
          nxt_data_o[i*W +: W] = lane_arr[i];
          nxt_valid_o[i]       = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/lxf_store_pipe.sv
module lxf_store_pipe #(
  parameter int N  = 64,
  parameter int W  = 16,
  parameter int AW = 10,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  word_i,
  input  logic [IW-1:0] dst_i,
  input  logic [AW-1:0] addr_i,
  output logic          busy_o,
  output logic [N-1:0]  wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [W-1:0]  wr_data_o,
  output logic          wr_done_o
);
  logic          s1_vld, s2_vld;
  logic [W-1:0]  s1_word;
  logic [IW-1:0] s1_dst, s2_dst;
  logic [AW-1:0] s1_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld    <= 1'b0;
      s1_word   <= '0;
      s1_dst    <= '0;
      s1_addr   <= '0;
      s2_vld    <= 1'b0;
      s2_dst    <= '0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      s1_vld <= start_i;
      if (start_i) begin
        s1_word <= word_i;
        s1_dst  <= dst_i;
        s1_addr <= addr_i;
      end
      s2_vld <= s1_vld;
      if (s1_vld) begin
        s2_dst    <= s1_dst;
        wr_addr_o <= s1_addr;
        wr_data_o <= s1_word;
      end
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_dec
    assign wr_en_o[j] = s2_vld && (s2_dst == IW'(j));
  end

  assign busy_o    = s1_vld;
  assign wr_done_o = s2_vld;

  assert_busy_one_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);
  assert_write_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (wr_en_o != '0));
  assert_no_start_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i);
endmodule

// File: rtl/lane_xfer_fabric.sv
module lane_xfer_fabric
  import lxf_pkg::*;
#(
  parameter int N  = 64,
  parameter int W  = 16,
  parameter int AW = 10,
  parameter int IW = $clog2(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic [1:0]      cmd_mode_i,
  input  logic [IW-1:0]   cmd_src_i,
  input  logic [IW-1:0]   cmd_dst_i,
  input  logic [AW-1:0]   cmd_addr_i,
  input  logic [N*W-1:0]  lane_data_i,
  output logic [N*W-1:0]  rx_data_o,
  output logic [N-1:0]    rx_valid_o,
  output logic [N-1:0]    wr_en_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [W-1:0]    wr_data_o,
  output logic            busy_o,
  output logic            done_o
);
  xfer_mode_e     mode;
  logic           accept, is_store, route_go, route_done, wr_done;
  logic [N*W-1:0] nxt_data;
  logic [N-1:0]   nxt_valid;

  assign mode     = xfer_mode_e'(cmd_mode_i);
  assign accept   = cmd_valid_i && !busy_o;
  assign is_store = (mode == XF_STORE);
  assign route_go = accept && !is_store;

  lxf_router #(.N(N), .W(W), .IW(IW)) u_router (
    .mode_i      (mode),
    .src_i       (cmd_src_i),
    .lane_data_i (lane_data_i),
    .nxt_data_o  (nxt_data),
    .nxt_valid_o (nxt_valid)
  );

  lxf_store_pipe #(.N(N), .W(W), .AW(AW), .IW(IW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept && is_store),
    .word_i    (lane_data_i[cmd_src_i*W +: W]),
    .dst_i     (cmd_dst_i),
    .addr_i    (cmd_addr_i),
    .busy_o    (busy_o),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .wr_done_o (wr_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o  <= '0;
      rx_valid_o <= '0;
      route_done <= 1'b0;
    end else begin
      route_done <= route_go;
      rx_valid_o <= route_go ? nxt_valid : '0;
      if (route_go) rx_data_o <= nxt_data;
    end
  end

  assign done_o = route_done | wr_done;

  assert_wr_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_o));
  assert_done_matches_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == ((rx_valid_o != '0) || (wr_en_o != '0)));
  assert_reject_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_valid_i) |=> (rx_valid_o == '0));
  assert_store_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o != '0) |-> (rx_valid_o == '0));
  assert_hold_on_store_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o != '0) |-> $stable(rx_data_o));
endmodule

// File: tb/sim_lane_xfer_fabric.sv
`timescale 1ns/1ps
module sim_lane_xfer_fabric;
  localparam int N  = 8;
  localparam int W  = 16;
  localparam int AW = 10;
  localparam int IW = $clog2(N);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmd_valid = 1'b0;
  logic [1:0]      cmd_mode = '0;
  logic [IW-1:0]   cmd_src = '0, cmd_dst = '0;
  logic [AW-1:0]   cmd_addr = '0;
  logic [N*W-1:0]  lane_data = '0;
  logic [N*W-1:0]  rx_data;
  logic [N-1:0]    rx_valid, wr_en;
  logic [AW-1:0]   wr_addr;
  logic [W-1:0]    wr_data;
  logic            busy, done;

  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  lane_xfer_fabric #(.N(N), .W(W), .AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_mode_i(cmd_mode),
    .cmd_src_i(cmd_src), .cmd_dst_i(cmd_dst), .cmd_addr_i(cmd_addr),
    .lane_data_i(lane_data), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .busy_o(busy), .done_o(done)
  );

  // behavioural reference
  logic [W-1:0]  m_rx [N];
  logic [N-1:0]  m_rxv = '0, m_wren = '0;
  logic [AW-1:0] m_addr = '0, p_addr = '0;
  logic [W-1:0]  m_wdata = '0, p_data = '0;
  int            p_dst = 0;
  bit            m_busy = 0, m_done = 0, pend = 0;
  string         m_tag = "R1";

  initial for (int i = 0; i < N; i++) m_rx[i] = '0;

  function automatic logic [W-1:0] lw(int i);
    return lane_data[i*W +: W];
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      bit acc;
      acc    = cmd_valid && !pend;
      m_rxv  = '0;
      m_wren = '0;
      m_done = 0;
      m_tag  = cmd_valid ? "R6" : "R7";
      if (pend) begin
        m_wren[p_dst] = 1'b1;
        m_addr  = p_addr;
        m_wdata = p_data;
        m_done  = 1;
        pend    = 0;
        m_tag   = "R5";
      end
      if (acc) begin
        case (cmd_mode)
          2'd0: begin
            for (int i = N-1; i >= 0; i--) m_rx[i] = (i == 0) ? '0 : lw(i-1);
            m_rxv = '1; m_done = 1; m_tag = "R2";
          end
          2'd1: begin
            for (int i = 0; i < N; i++) m_rx[i] = (i == N-1) ? '0 : lw(i+1);
            m_rxv = '1; m_done = 1; m_tag = "R3";
          end
          2'd2: begin
            for (int i = 0; i < N; i++) begin
              m_rx[i]  = lw(int'(cmd_src));
              m_rxv[i] = (i != int'(cmd_src));
            end
            m_done = 1; m_tag = "R4";
          end
          default: begin
            pend   = 1;
            p_dst  = int'(cmd_dst);
            p_addr = cmd_addr;
            p_data = lw(int'(cmd_src));
            m_tag  = "R9";
          end
        endcase
      end
      m_busy = pend;
    end
  end

  task automatic chk(bit ok, string req, string what, logic [N*W-1:0] act, logic [N*W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [N*W-1:0] exp_rx;
      cycles++;
      for (int i = 0; i < N; i++) exp_rx[i*W +: W] = m_rx[i];
      chk(busy == m_busy, "R6", "busy", N*W'(busy), N*W'(m_busy));
      chk(done == m_done, "R7", "done", N*W'(done), N*W'(m_done));
      chk(rx_valid == m_rxv, m_tag, "rx_valid", N*W'(rx_valid), N*W'(m_rxv));
      chk(rx_data == exp_rx, m_tag, "rx_data", rx_data, exp_rx);
      chk(wr_en == m_wren, (m_wren != '0) ? "R8" : "R9", "wr_en", N*W'(wr_en), N*W'(m_wren));
      if (m_wren != '0) begin
        chk(wr_addr == m_addr, "R5", "wr_addr", N*W'(wr_addr), N*W'(m_addr));
        chk(wr_data == m_wdata, "R5", "wr_data", N*W'(wr_data), N*W'(m_wdata));
      end
    end
  end

  task automatic rnd_lanes();
    for (int i = 0; i < N; i++) lane_data[i*W +: W] = W'($urandom);
  endtask

  task automatic issue(int mode, int src, int dst, int addr);
    @(negedge clk);
    rnd_lanes();
    cmd_valid = 1'b1;
    cmd_mode  = 2'(mode);
    cmd_src   = IW'(src);
    cmd_dst   = IW'(dst);
    cmd_addr  = AW'(addr);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      rnd_lanes();
    end
  endtask

  initial begin
    #1;
    // R1: reset values
    chk(!busy && !done, "R1", "busy/done", N*W'({busy, done}), '0);
    chk(rx_valid == '0 && wr_en == '0, "R1", "strobes", N*W'({rx_valid, wr_en}), '0);
    chk(rx_data == '0, "R1", "rx_data", rx_data, '0);
    #10 rst_n = 1'b1;
    idle(2);
    issue(0, 0, 0, 0); idle(1);            // R2
    issue(1, 0, 0, 0); idle(1);            // R3
    issue(2, 0, 0, 0); idle(1);            // R4 first lane
    issue(2, N-1, 0, 0); idle(1);          // R4 last lane
    issue(2, 3, 0, 0); idle(1);            // R4 middle
    issue(0, 0, 0, 0); issue(1, 0, 0, 0); issue(2, 5, 0, 0); idle(1);
    issue(3, 2, 5, 'h155);                 // R5
    issue(0, 0, 0, 0);                     // R6 rejected, lanes change
    idle(2);
    issue(3, 7, 0, 'h2a); issue(2, 1, 0, 0); issue(3, 0, N-1, 'h3ff); idle(3);
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 3) == 0) idle(1);
      else issue($urandom_range(0, 3), $urandom_range(0, N-1),
                 $urandom_range(0, N-1), $urandom_range(0, (1 << AW) - 1));
    end
    idle(4);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule